// File: doc/BRIEF.md
# Buffered Block Write Unit

This unit carries out the buffered-write sequence of a parallel flash command interpreter. Once the interpreter has accepted the buffered-write command, it raises `start`. The next write on the shared write bus then supplies a word count. The writes after that are data words. They are collected into a staging buffer that covers one aligned window of the array. The window is chosen by the first data write, which is aligned down to the write-block size of 2^`WB_LG2` bytes.

The write after the last data word is the confirm write. If its low byte is 0xD0 and the shared programming-error flag is clear, the buffer is committed, one word per clock. The array only ever sees a complete window update. Any other confirm value discards the buffer and tells the interpreter to return to read-array mode. An `abort` from the interpreter, or a reset, also discards the buffer.

Status bit 4 (programming error) and status bit 7 (ready) live in the interpreter's status register. This unit asks for them to be set through one-cycle pulses, and it reads bit 4 back on `pe_in`. For a full-size part, the window size follows this rule: 2^8 bytes for a one-byte bank and 2^11 bytes otherwise, multiplied by the number of devices in the bank. The package function `std_wb_lg2` gives that value. Small windows are meant for tests.

Top module: `blkwr_unit`

## Requirements
- R1: The first write after `start` loads the word count from the low CNT_W bits of `wr_data`, and all higher bits are ignored. CNT_W is 8 times `DEV_BYTES`, or 8 times `BANK_BYTES` when `DEV_BYTES` is 0. With the default parameters, a count write of 0x0302 means a count of 2.
- R2: A count of N accepts exactly N+1 data writes. The write after those is treated as the confirm write.
- R3: A commit writes to the array only the words stored during the sequence, at their own addresses, and every other array word keeps its value. The window is the first data write's byte address aligned down to 2^`WB_LG2` bytes. Data is stored at the word address (`wr_addr` with its low log2(`BANK_BYTES`) bits cleared), and a later write to the same word replaces an earlier one.
- R4: A data write is not stored, and `set_pe` is high in its cycle, when its first byte or its last byte (address + `BANK_BYTES` - 1) lies outside the open window.
- R5: With a count of 0 the window never opens. The single data write then raises `set_pe` and stores nothing.
- R6: While `wp` is high, a data write raises `set_pe` and stores nothing.
- R7: `set_rdy` is high in the cycle of every data write.
- R8: The confirm write is rejected when its low byte differs from 0xD0 or `pe_in` is high. A rejected confirm raises `to_read_array` in its own cycle and drops `active` in the next cycle, and the array is left unchanged.
- R9: The confirm write is accepted when its low byte is 0xD0 and `pe_in` is low. `busy` is then high for exactly 2^`WB_LG2`/`BANK_BYTES` cycles, starting in the next cycle. `mem_we` is high only while `busy` is high, `set_rdy` is high in the last busy cycle, and `active` is low once `busy` falls.
- R10: `start`, `abort` and bus writes made while `busy` is high have no effect: the commit result is unchanged and `active` is low after the commit.
- R11: `abort` while `active` is high and `busy` is low makes `active` low in the next cycle and leaves the array unchanged.
- R12: Reset makes `active` low at once and discards the buffer, leaving the array unchanged.
- R13: Out of reset, `active`, `busy`, `mem_we`, `set_pe`, `set_rdy` and `to_read_array` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wp | input | 1 | Write protect; data writes are refused while high |
| start | input | 1 | One-cycle pulse: the interpreter accepted the buffered-write command |
| abort | input | 1 | One-cycle pulse: the interpreter cancels the sequence |
| wr_en | input | 1 | Bus write strobe, one cycle per write |
| wr_addr | input | ADDR_W | Byte address of the bus write |
| wr_data | input | 8*BANK_BYTES | Bus write data |
| pe_in | input | 1 | Programming-error status bit (bit 4) from the interpreter |
| active | output | 1 | The unit owns the bus writes (a sequence is in progress) |
| busy | output | 1 | Commit in progress |
| set_pe | output | 1 | Pulse requesting that status bit 4 be set |
| set_rdy | output | 1 | Pulse requesting that status bit 7 be set |
| to_read_array | output | 1 | Pulse requesting that the interpreter return to read-array mode |
| mem_we | output | 1 | Array word write enable |
| mem_addr | output | ADDR_W | Array byte address of the word being written |
| mem_wdata | output | 8*BANK_BYTES | Array write data |

## Verification
The bench sweeps every window of a small array with counts from 0 up to the window length, using ascending, descending and repeating address patterns. It predicts the array contents word by word. Sequences that run off the end of the window, and a misaligned word that straddles the window's last byte, must be refused and then discarded at confirm; a design that checked only the start address would commit a corrupt window. The bench also covers a count of zero, which must never open a window and so must never commit, and a count whose high bits are set, which would swallow the confirm write as data if it were not masked. It holds the bus busy during a commit, where a design that listened would start a new sequence or change a committed word.

// File: rtl/blkwr_pkg.sv
package blkwr_pkg;

  typedef enum logic [2:0] {
    BW_IDLE    = 3'd0,
    BW_COUNT   = 3'd1,
    BW_DATA    = 3'd2,
    BW_CONFIRM = 3'd3,
    BW_COMMIT  = 3'd4
  } bw_state_e;

  localparam logic [7:0] CONFIRM_CODE = 8'hD0;

  // Width of the word-count field: the device width, or the bank width when
  // no device width is configured (0).
  function automatic int cnt_bits(input int bank_bytes, input int dev_bytes);
    return 8 * ((dev_bytes != 0) ? dev_bytes : bank_bytes);
  endfunction

  // Write-block size (log2 of bytes) of a full-size part.
  function automatic int std_wb_lg2(input int bank_bytes, input int dev_bytes);
    int ndev;
    ndev = (dev_bytes != 0) ? (bank_bytes / dev_bytes) : 1;
    return ((bank_bytes == 1) ? 8 : 11) + $clog2(ndev);
  endfunction

endpackage

// File: rtl/blkwr_ctrl.sv
module blkwr_ctrl
  import blkwr_pkg::*;
#(
  parameter int ADDR_W     = 8,
  parameter int CNT_W      = 8,
  parameter int WB_LG2     = 4,
  parameter int WORD_LG    = 1,
  parameter int BANK_BYTES = 2,
  localparam int TAG_W     = ADDR_W - WB_LG2,
  localparam int IDX_W     = WB_LG2 - WORD_LG
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic              abort,
  input  logic              wp,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [CNT_W-1:0]  cnt_in,
  input  logic              pe_in,
  input  logic              commit_done,
  output bw_state_e         state,
  output logic              open,
  output logic [TAG_W-1:0]  win_tag,
  output logic              stg_clr,
  output logic              stg_wr,
  output logic [IDX_W-1:0]  stg_idx,
  output logic              ev_data_wr,
  output logic              ev_commit_go,
  output logic              ev_discard,
  output logic              set_pe
);

  bw_state_e         state_q, state_d;
  logic [CNT_W-1:0]  cnt_q, cnt_d;
  logic              open_q, open_d;
  logic [TAG_W-1:0]  tag_q, tag_d;

  logic              opening, eff_open, hit, store, abort_ok, cfm_wr;
  logic [TAG_W-1:0]  addr_tag, end_tag, cur_tag;

  function automatic logic [TAG_W-1:0] tag_of(input logic [ADDR_W-1:0] a);
    return a[ADDR_W-1:WB_LG2];
  endfunction

  function automatic logic [ADDR_W-1:0] last_byte(input logic [ADDR_W-1:0] a);
    return a + ADDR_W'(BANK_BYTES - 1);
  endfunction

  assign addr_tag   = tag_of(wr_addr);
  assign end_tag    = tag_of(last_byte(wr_addr));

  assign ev_data_wr = (state_q == BW_DATA) && wr_en;
  assign opening    = ev_data_wr && !open_q && (cnt_q != '0);
  assign eff_open   = open_q || opening;
  assign cur_tag    = opening ? addr_tag : tag_q;
  assign hit        = (addr_tag == cur_tag) && (end_tag == cur_tag);
  assign store      = ev_data_wr && eff_open && !wp && hit;
  assign set_pe     = ev_data_wr && !store;

  assign stg_clr    = opening;
  assign stg_wr     = store;
  assign stg_idx    = wr_addr[WB_LG2-1:WORD_LG];

  assign cfm_wr       = (state_q == BW_CONFIRM) && wr_en;
  assign abort_ok     = abort && (state_q != BW_IDLE) && (state_q != BW_COMMIT);
  assign ev_commit_go = cfm_wr && !abort_ok && (cnt_in[7:0] == CONFIRM_CODE) && !pe_in;
  assign ev_discard   = cfm_wr && !abort_ok && !ev_commit_go;

  always_comb begin
    state_d = state_q;
    cnt_d   = cnt_q;
    open_d  = open_q;
    tag_d   = tag_q;
    unique case (state_q)
      BW_IDLE: begin
        open_d = 1'b0;
        if (start) state_d = BW_COUNT;
      end
      BW_COUNT: begin
        if (wr_en) begin
          cnt_d   = cnt_in;
          state_d = BW_DATA;
        end
      end
      BW_DATA: begin
        if (wr_en) begin
          if (opening) begin
            open_d = 1'b1;
            tag_d  = addr_tag;
          end
          if (cnt_q == '0) state_d = BW_CONFIRM;
          else             cnt_d   = cnt_q - CNT_W'(1);
        end
      end
      BW_CONFIRM: begin
        if (ev_commit_go) begin
          state_d = BW_COMMIT;
        end else if (wr_en) begin
          state_d = BW_IDLE;
          open_d  = 1'b0;
        end
      end
      BW_COMMIT: begin
        if (commit_done) begin
          state_d = BW_IDLE;
          open_d  = 1'b0;
        end
      end
      default: begin
        state_d = BW_IDLE;
        open_d  = 1'b0;
      end
    endcase
    if (abort_ok) begin
      state_d = BW_IDLE;
      open_d  = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= BW_IDLE;
      cnt_q   <= '0;
      open_q  <= 1'b0;
      tag_q   <= '0;
    end else begin
      state_q <= state_d;
      cnt_q   <= cnt_d;
      open_q  <= open_d;
      tag_q   <= tag_d;
    end
  end

  assign state   = state_q;
  assign open    = open_q;
  assign win_tag = tag_q;

endmodule

// File: rtl/blkwr_stage.sv
module blkwr_stage #(
  parameter int DATA_W = 16,
  parameter int IDX_W  = 3,
  localparam int WORDS = 1 << IDX_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clr,
  input  logic              wr,
  input  logic [IDX_W-1:0]  widx,
  input  logic [DATA_W-1:0] wdata,
  input  logic [IDX_W-1:0]  ridx,
  output logic [DATA_W-1:0] rdata,
  output logic              rdirty
);

  logic [DATA_W-1:0] word_q [WORDS];
  logic [WORDS-1:0]  dirty_q, dirty_d;

  // Dirty bits mark the words written since the window opened; clean words
  // keep the array's value, which is what a snapshot copy would hold.
  always_comb begin
    dirty_d = clr ? '0 : dirty_q;
    if (wr) dirty_d[widx] = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) dirty_q <= '0;
    else        dirty_q <= dirty_d;
  end

  for (genvar g = 0; g < WORDS; g++) begin : g_word
    always_ff @(posedge clk) begin
      if (wr && (widx == IDX_W'(g))) word_q[g] <= wdata;
    end
  end

  assign rdata  = word_q[ridx];
  assign rdirty = dirty_q[ridx];

endmodule

// File: rtl/blkwr_commit.sv
module blkwr_commit #(
  parameter int IDX_W  = 3,
  localparam int WORDS = 1 << IDX_W
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             go,
  input  logic             running,
  output logic [IDX_W-1:0] idx,
  output logic             done
);

  logic [IDX_W-1:0] idx_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       idx_q <= '0;
    else if (go)      idx_q <= '0;
    else if (running) idx_q <= idx_q + IDX_W'(1);
  end

  assign idx  = idx_q;
  assign done = running && (idx_q == IDX_W'(WORDS - 1));

endmodule

// File: rtl/blkwr_unit.sv
module blkwr_unit
  import blkwr_pkg::*;
#(
  parameter int BANK_BYTES = 2,
  parameter int DEV_BYTES  = 1,
  parameter int ADDR_W     = 8,
  parameter int WB_LG2     = 4,
  localparam int DATA_W    = 8 * BANK_BYTES,
  localparam int WORD_LG   = $clog2(BANK_BYTES),
  localparam int CNT_W     = cnt_bits(BANK_BYTES, DEV_BYTES),
  localparam int IDX_W     = WB_LG2 - WORD_LG,
  localparam int TAG_W     = ADDR_W - WB_LG2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wp,
  input  logic              start,
  input  logic              abort,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              pe_in,
  output logic              active,
  output logic              busy,
  output logic              set_pe,
  output logic              set_rdy,
  output logic              to_read_array,
  output logic              mem_we,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [DATA_W-1:0] mem_wdata
);

  bw_state_e         state;
  logic              open, stg_clr, stg_wr, ev_data_wr, ev_commit_go, ev_discard;
  logic              commit_done, rdirty;
  logic [TAG_W-1:0]  win_tag;
  logic [IDX_W-1:0]  stg_idx, cm_idx;

  function automatic logic [ADDR_W-1:0] word_byte_addr(input logic [TAG_W-1:0] t,
                                                       input logic [IDX_W-1:0] i);
    logic [ADDR_W-1:0] a;
    a = ADDR_W'({t, i});
    return a << WORD_LG;
  endfunction

  blkwr_ctrl #(
    .ADDR_W(ADDR_W), .CNT_W(CNT_W), .WB_LG2(WB_LG2), .WORD_LG(WORD_LG),
    .BANK_BYTES(BANK_BYTES)
  ) u_ctrl (
    .clk(clk), .rst_n(rst_n), .start(start), .abort(abort), .wp(wp),
    .wr_en(wr_en), .wr_addr(wr_addr), .cnt_in(wr_data[CNT_W-1:0]),
    .pe_in(pe_in), .commit_done(commit_done), .state(state), .open(open),
    .win_tag(win_tag), .stg_clr(stg_clr), .stg_wr(stg_wr), .stg_idx(stg_idx),
    .ev_data_wr(ev_data_wr), .ev_commit_go(ev_commit_go),
    .ev_discard(ev_discard), .set_pe(set_pe)
  );

  blkwr_stage #(.DATA_W(DATA_W), .IDX_W(IDX_W)) u_stage (
    .clk(clk), .rst_n(rst_n), .clr(stg_clr), .wr(stg_wr), .widx(stg_idx),
    .wdata(wr_data), .ridx(cm_idx), .rdata(mem_wdata), .rdirty(rdirty)
  );

  blkwr_commit #(.IDX_W(IDX_W)) u_commit (
    .clk(clk), .rst_n(rst_n), .go(ev_commit_go), .running(busy),
    .idx(cm_idx), .done(commit_done)
  );

  assign active        = (state != BW_IDLE);
  assign busy          = (state == BW_COMMIT);
  assign set_rdy       = ev_data_wr || commit_done;
  assign to_read_array = ev_discard;
  assign mem_we        = busy && open && rdirty;
  assign mem_addr      = word_byte_addr(win_tag, cm_idx);

endmodule

// File: rtl/blkwr_unit_chk.sv
module blkwr_unit_chk #(
  parameter int BANK_BYTES = 2,
  parameter int WB_LG2     = 4,
  localparam int WORDS     = (1 << WB_LG2) / BANK_BYTES
) (
  input logic clk,
  input logic rst_n,
  input logic abort,
  input logic active,
  input logic busy,
  input logic mem_we,
  input logic set_pe,
  input logic set_rdy,
  input logic to_read_array,
  input logic ev_data_wr
);

  int unsigned busy_run;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    busy_run <= 0;
    else if (busy) busy_run <= busy_run + 1;
    else           busy_run <= 0;
  end

  p_we_in_commit_r9: assert property (@(posedge clk) disable iff (!rst_n)
    mem_we |-> busy);

  p_commit_bound_r9: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> (busy_run < WORDS));

  p_commit_full_r9: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> (busy_run == WORDS && !active));

  p_rdy_on_data_r7: assert property (@(posedge clk) disable iff (!rst_n)
    ev_data_wr |-> set_rdy);

  p_discard_idle_r8: assert property (@(posedge clk) disable iff (!rst_n)
    to_read_array |=> !active);

  p_no_pe_commit_r10: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> !set_pe && !to_read_array);

  p_abort_idle_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (abort && active && !busy) |=> !active);

endmodule

bind blkwr_unit blkwr_unit_chk #(.BANK_BYTES(BANK_BYTES), .WB_LG2(WB_LG2)) u_chk (
  .clk(clk), .rst_n(rst_n), .abort(abort), .active(active), .busy(busy),
  .mem_we(mem_we), .set_pe(set_pe), .set_rdy(set_rdy),
  .to_read_array(to_read_array), .ev_data_wr(ev_data_wr)
);

// File: tb/blkwr_unit_tb.sv
module blkwr_unit_tb;

  localparam int CLK_PERIOD = 10;
  localparam int WORDS      = 8;    // 16-byte window, 2-byte words
  localparam int MEMW       = 128;  // 256-byte array

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wp = 1'b0, start = 1'b0, abort = 1'b0, wr_en = 1'b0, pe_in = 1'b0;
  logic [7:0]  wr_addr = '0;
  logic [15:0] wr_data = '0;
  logic        active, busy, set_pe, set_rdy, to_read_array, mem_we;
  logic [7:0]  mem_addr;
  logic [15:0] mem_wdata;

  logic [15:0] arr [MEMW];
  logic [15:0] expv [MEMW];
  int total = 0, bad = 0;
  logic s_pe, s_rdy, s_rar;

  always #(CLK_PERIOD/2) clk = ~clk;

  blkwr_unit u_dut (
    .clk(clk), .rst_n(rst_n), .wp(wp), .start(start), .abort(abort),
    .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data), .pe_in(pe_in),
    .active(active), .busy(busy), .set_pe(set_pe), .set_rdy(set_rdy),
    .to_read_array(to_read_array), .mem_we(mem_we), .mem_addr(mem_addr),
    .mem_wdata(mem_wdata)
  );

  always @(posedge clk) if (mem_we) arr[mem_addr[7:1]] <= mem_wdata;

  task automatic chk(input string nm, input int act, input int ex);
    total++;
    if (act != ex) begin
      bad++;
      $display("FAIL %s: actual=%0h expected=%0h", nm, act, ex);
    end
  endtask

  task automatic bus_wr(input logic [7:0] a, input logic [15:0] d, input logic pe);
    @(negedge clk);
    wr_en = 1'b1; wr_addr = a; wr_data = d; pe_in = pe;
    #1;
    s_pe = set_pe; s_rdy = set_rdy; s_rar = to_read_array;
    @(posedge clk); #1;
    wr_en = 1'b0;
  endtask

  task automatic pulse_start();
    @(negedge clk); start = 1'b1;
    @(posedge clk); #1; start = 1'b0;
  endtask

  task automatic check_array(input string nm);
    int mism = 0;
    for (int i = 0; i < MEMW; i++) if (arr[i] !== expv[i]) mism++;
    chk(nm, mism, 0);
  endtask

  // One full sequence; expected results derived from the requirements.
  task automatic burst(input int wstart, input int cnt_raw, input int nwr,
                       input int step, input int boff, input bit wpv,
                       input logic [7:0] code, input bit poke);
    int cnt, ba, wi, tagw, nb, nr;
    bit opened, store, lpe, go;
    logic [15:0] tmp [MEMW];
    logic [15:0] d;
    for (int i = 0; i < MEMW; i++) tmp[i] = expv[i];
    cnt = cnt_raw & 8'hFF;
    opened = (cnt != 0);
    lpe = 1'b0; tagw = 0;
    wp = wpv;
    pulse_start();
    bus_wr(8'h00, 16'(cnt_raw), 1'b0);
    for (int k = 0; k < nwr; k++) begin
      wi = (wstart + k * step) & (MEMW - 1);
      ba = (wi * 2 + boff) & 255;
      if (k == 0) tagw = ba >> 4;
      store = opened && !wpv && ((ba >> 4) == tagw) && ((((ba + 1) & 255) >> 4) == tagw);
      d = 16'hA000 ^ 16'(wi * 16'h0123) ^ 16'(k);
      bus_wr(8'(ba), d, lpe);
      chk($sformatf("R4 R5 R6 set_pe w%0d k%0d", wstart, k), s_pe, !store);
      chk($sformatf("R7 set_rdy w%0d k%0d", wstart, k), s_rdy, 1);
      if (store) tmp[ba >> 1] = d;
      if (!store) lpe = 1'b1;
    end
    go = (code == 8'hD0) && !lpe;
    bus_wr(8'h00, {8'h00, code}, lpe);
    chk($sformatf("R2 R8 discard pulse w%0d", wstart), s_rar, !go);
    if (go) begin
      nb = 0; nr = 0;
      @(negedge clk);
      while (busy) begin
        nb++;
        if (set_rdy) nr++;
        if (poke) begin
          wr_en = 1'b1; wr_addr = 8'(tagw << 4); wr_data = 16'hDEAD;
          start = 1'b1; abort = 1'b1;
        end
        @(negedge clk);
      end
      wr_en = 1'b0; start = 1'b0; abort = 1'b0;
      chk($sformatf("R9 busy length w%0d", wstart), nb, WORDS);
      chk($sformatf("R9 rdy at end w%0d", wstart), nr, 1);
      for (int i = 0; i < MEMW; i++) expv[i] = tmp[i];
    end else begin
      #1;
    end
    chk($sformatf("R8 R9 R10 idle after w%0d", wstart), active, 0);
    check_array($sformatf("R3 array after w%0d", wstart));
    wp = 1'b0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    bad++;
    $display("FAIL watchdog: actual=hung expected=finish");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    for (int i = 0; i < MEMW; i++) begin
      arr[i]  = 16'(i * 16'h0101 + 16'h5A00);
      expv[i] = 16'(i * 16'h0101 + 16'h5A00);
    end
    repeat (3) @(negedge clk);
    chk("R13 active at reset", active, 0);
    chk("R13 busy at reset", busy, 0);
    chk("R13 mem_we at reset", mem_we, 0);
    chk("R13 pulses at reset", {set_pe, set_rdy, to_read_array}, 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R13 idle after release", active, 0);

    // Sweep over all windows with varied counts and directions.
    for (int w = 0; w < 16; w++)
      burst(w * WORDS + (w % 3), w % WORDS, (w % WORDS) + 1,
            (w % 2) ? -1 : 1, 0, 1'b0, 8'hD0, 1'b0);

    burst(16, 16'h0302, 3, 1, 0, 1'b0, 8'hD0, 1'b0);   // R1 masked count
    burst(96, 7, 8, 1, 0, 1'b0, 8'hD0, 1'b0);          // R3 full window
    burst(42, 9, 10, 0, 0, 1'b0, 8'hD0, 1'b0);         // R2 R3 repeated word
    burst(24, 3, 4, 1, 0, 1'b1, 8'hD0, 1'b0);          // R6 write protect
    burst(32, 0, 1, 1, 0, 1'b0, 8'hD0, 1'b0);          // R5 zero count
    burst(56, 2, 3, 1, 0, 1'b0, 8'h55, 1'b0);          // R8 wrong code
    burst(58, 1, 2, 1, 0, 1'b0, 8'hFF, 1'b0);          // R8 read-array code
    burst(64, 1, 2, 7, 1, 1'b0, 8'hD0, 1'b0);          // R4 straddling word
    burst(80, 7, 8, 1, 0, 1'b0, 8'hD0, 1'b1);          // R10 bus busy

    // R11 abort mid-sequence
    pulse_start();
    bus_wr(8'h00, 16'd3, 1'b0);
    bus_wr(8'hA0, 16'h1111, 1'b0);
    bus_wr(8'hA2, 16'h2222, 1'b0);
    @(negedge clk); abort = 1'b1;
    @(posedge clk); #1; abort = 1'b0;
    chk("R11 idle after abort", active, 0);
    bus_wr(8'hA4, 16'h3333, 1'b0);
    bus_wr(8'h00, 16'h00D0, 1'b0);
    repeat (WORDS + 2) @(negedge clk);
    chk("R11 no commit after abort", busy, 0);
    check_array("R11 array after abort");

    // R12 reset mid-sequence
    pulse_start();
    bus_wr(8'h00, 16'd1, 1'b0);
    bus_wr(8'hC0, 16'h4444, 1'b0);
    @(negedge clk); rst_n = 1'b0; #1;
    chk("R12 idle in reset", active, 0);
    @(negedge clk); rst_n = 1'b1;
    bus_wr(8'hC2, 16'h5555, 1'b0);
    bus_wr(8'h00, 16'h00D0, 1'b0);
    repeat (WORDS + 2) @(negedge clk);
    chk("R12 no commit after reset", busy, 0);
    check_array("R12 array after reset");

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule